// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD timing controller's supply rails and control port up and down in a fixed, safe order. It issues one-cycle register writes (3-bit address, 8-bit data) to the controller's serial port, and it holds timed pauses between some of them. At two points it hands an 8-bit bias code to an external serial DAC writer, and it waits for that writer to finish before going on. The bias code sets the common-electrode voltage.

A power-up request runs the full bring-up sequence if the panel is not yet initialised. If the panel is already initialised, the request only refreshes the phase and resolution registers. A suspend request lets two frames drain, then drops the rails in reverse order and zeroes the bias. The block latches the following at the moment it accepts a request: the mode select (VGA or QVGA), a stored phase value with its valid flag, and a stored bias value with its valid flag. Pauses are counted in milliseconds by a prescaler whose length is a parameter. An `inited` flag records whether the panel is up.

The controller has five states:
- `S_IDLE` waits for a request.
- `S_ISSUE` presents the current step.
- `S_HOLD` waits for the millisecond timer.
- `S_BIAS` waits for the DAC writer's acknowledge.
- `S_FINISH` pulses `done` and updates `inited`.

The transitions are:
- accept: `S_IDLE` to `S_ISSUE`.
- pause: `S_ISSUE` to `S_HOLD`.
- bias: `S_ISSUE` to `S_BIAS`.
- resume: `S_HOLD` or `S_BIAS` back to `S_ISSUE`.
- end: `S_ISSUE` to `S_FINISH`.
- retire: `S_FINISH` to `S_IDLE`.

Top module: `lcd_pwr_seq`

## Requirements
- R1: After reset, `wr_en`, `bias_go`, `busy`, `done` and `inited` are all 0.
- R2: A power-up from the uninitialised state writes, in order (address:data, hex), 6:1F, 3:03, 4:00, 4:04, 3:07, 6:09, then one bias write, then 3:17, 4:06, 6:01, 3:1F, 4:07, 6:00, then 1:phase, 7:00, 0:resolution. Power0 is address 3, with bit 2 DAC, bit 3 COM and bit 4 VCC5. Power1 is address 4, with bit 0 VW, bit 1 GVSS and bit 2 VDD. Port control is address 6.
- R3: The power-up bias code is the stored bias value when its valid flag is set, and 125 otherwise.
- R4: The phase byte is (v << 1) | 1. In QVGA mode (`mode_vga`=0), v is 9. In VGA mode, v is the low 4 bits of the stored phase, and the byte is 0x01 when the stored phase is not valid.
- R5: The resolution register (address 0) is the last write of any power-up, with 0x00 for VGA and 0x01 for QVGA.
- R6: The pause after the write 4:04 lasts 3 ms, the pause after 4:06 lasts 2 ms, and the pause after 7:00 lasts 1 ms. A pause of N ms spans between N*CYC_PER_MS and N*CYC_PER_MS+4 cycles from one write to the next event.
- R7: A power-up while `inited`=1 writes only 1:phase then 0:resolution.
- R8: A suspend first waits 34 ms. It then writes 4:06, 6:08, 3:14, performs a bias write of 0, and writes 4:04, 3:04, 6:1E, 3:00, 4:00. At the end it clears `inited`.
- R9: `done` is high for exactly one cycle at the end of each sequence. `inited` is 1 after a power-up completes.
- R10: A request that arrives while `busy`=1 is ignored. If both requests arrive together in idle, the suspend is taken.
- R11: `bias_go` is a one-cycle pulse, with `bias_val` valid in that cycle. No further event occurs until `bias_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up_req | input | 1 | Power-up request, sampled in idle |
| suspend_req | input | 1 | Suspend request, sampled in idle |
| mode_vga | input | 1 | 1 = VGA, 0 = QVGA |
| phase_ok | input | 1 | Stored phase value valid |
| phase_val | input | 8 | Stored phase value |
| bias_ok | input | 1 | Stored bias value valid |
| bias_stored | input | 8 | Stored bias value |
| bias_ack | input | 1 | DAC writer finished |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register address |
| wr_data | output | 8 | Register data |
| bias_go | output | 1 | Start a bias DAC write |
| bias_val | output | 8 | Bias code for the DAC write |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle end-of-sequence pulse |
| inited | output | 1 | Panel is initialised |

## Verification
The bench targets four corner cases, each with the failure it would expose:
- A second power-up must take the short path. A design that forgot `inited` would replay the whole rail ladder.
- In VGA mode with the phase flag cleared, the phase byte must collapse to 0x01. A design that forgot this would leak stray bits into the byte.
- Requests pulsed in mid-sequence, and a simultaneous power-up and suspend, must not restart or corrupt the running order.
- The pause widths are measured against the prescaled millisecond count. The DAC acknowledge is delayed by varying amounts, so a sequencer that did not wait for it would emit the next write too early.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

    localparam logic [2:0] A_RES   = 3'd0;
    localparam logic [2:0] A_PHASE = 3'd1;
    localparam logic [2:0] A_PWR0  = 3'd3;
    localparam logic [2:0] A_PWR1  = 3'd4;
    localparam logic [2:0] A_PORT  = 3'd6;
    localparam logic [2:0] A_POL   = 3'd7;

    localparam int STEP_W = 5;
    localparam int WAIT_W = 6;

    typedef enum logic [1:0] {
        K_WR   = 2'd0,
        K_BIAS = 2'd1,
        K_NOP  = 2'd2,
        K_END  = 2'd3
    } kind_t;

    typedef struct packed {
        kind_t             kind;
        logic [2:0]        addr;
        logic [7:0]        data;
        logic [WAIT_W-1:0] wait_ms;
    } step_t;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ISSUE  = 3'd1,
        S_HOLD   = 3'd2,
        S_BIAS   = 3'd3,
        S_FINISH = 3'd4
    } state_t;

    function automatic step_t mk(kind_t k, logic [2:0] a, logic [7:0] d, logic [WAIT_W-1:0] w);
        step_t s;
        s.kind = k;
        s.addr = a;
        s.data = d;
        s.wait_ms = w;
        return s;
    endfunction

endpackage

// File: rtl/lcdseq_ms_timer.sv
module lcdseq_ms_timer #(
    parameter int CYC_PER_MS = 50000,
    parameter int MS_W       = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MS_W-1:0] ms,
    output logic            expired
);
    localparam int PRE_W = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_MS - 1);

    logic [PRE_W-1:0] pre;
    logic [MS_W-1:0]  ms_left;
    logic             run;

    assign expired = run && (pre == PRE_LAST) && (ms_left == MS_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre     <= '0;
            ms_left <= '0;
            run     <= 1'b0;
        end else if (start) begin
            pre     <= '0;
            ms_left <= ms;
            run     <= (ms != '0);
        end else if (run) begin
            if (pre == PRE_LAST) begin
                pre <= '0;
                if (ms_left == MS_W'(1)) run <= 1'b0;
                else ms_left <= ms_left - 1'b1;
            end else begin
                pre <= pre + 1'b1;
            end
        end
    end

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run);
    // R6
    stop_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(expired));
endmodule

// File: rtl/lcdseq_phase_enc.sv
module lcdseq_phase_enc #(
    parameter int QVGA_PHASE = 9
) (
    input  logic       vga,
    input  logic       ok,
    input  logic [7:0] stored,
    output logic [7:0] phase_byte,
    output logic [7:0] res_byte
);
    localparam logic [3:0] QV = 4'(QVGA_PHASE);

    always_comb begin
        if (!vga)     phase_byte = {3'b000, QV, 1'b1};
        else if (ok)  phase_byte = {3'b000, stored[3:0], 1'b1};
        else          phase_byte = 8'h01;
        res_byte = vga ? 8'h00 : 8'h01;
    end
endmodule

// File: rtl/lcdseq_step_rom.sv
module lcdseq_step_rom
    import lcdseq_pkg::*;
#(
    parameter int VDD_MS    = 3,
    parameter int GVSS_MS   = 2,
    parameter int POL_MS    = 1,
    parameter int SETTLE_MS = 34
) (
    input  logic              down,
    input  logic [STEP_W-1:0] idx,
    input  logic [7:0]        phase_byte,
    input  logic [7:0]        res_byte,
    input  logic [7:0]        bias_byte,
    output step_t             step
);
    localparam logic [WAIT_W-1:0] W0 = '0;
    localparam logic [WAIT_W-1:0] WV = WAIT_W'(VDD_MS);
    localparam logic [WAIT_W-1:0] WG = WAIT_W'(GVSS_MS);
    localparam logic [WAIT_W-1:0] WP = WAIT_W'(POL_MS);
    localparam logic [WAIT_W-1:0] WS = WAIT_W'(SETTLE_MS);

    always_comb begin
        step = mk(K_END, 3'd0, 8'h00, W0);
        if (!down) begin
            unique case (idx)
                5'd0:  step = mk(K_WR,   A_PORT,  8'h1F, W0);
                5'd1:  step = mk(K_WR,   A_PWR0,  8'h03, W0);
                5'd2:  step = mk(K_WR,   A_PWR1,  8'h00, W0);
                5'd3:  step = mk(K_WR,   A_PWR1,  8'h04, WV);
                5'd4:  step = mk(K_WR,   A_PWR0,  8'h07, W0);
                5'd5:  step = mk(K_WR,   A_PORT,  8'h09, W0);
                5'd6:  step = mk(K_BIAS, 3'd0,    bias_byte, W0);
                5'd7:  step = mk(K_WR,   A_PWR0,  8'h17, W0);
                5'd8:  step = mk(K_WR,   A_PWR1,  8'h06, WG);
                5'd9:  step = mk(K_WR,   A_PORT,  8'h01, W0);
                5'd10: step = mk(K_WR,   A_PWR0,  8'h1F, W0);
                5'd11: step = mk(K_WR,   A_PWR1,  8'h07, W0);
                5'd12: step = mk(K_WR,   A_PORT,  8'h00, W0);
                5'd13: step = mk(K_WR,   A_PHASE, phase_byte, W0);
                5'd14: step = mk(K_WR,   A_POL,   8'h00, WP);
                5'd15: step = mk(K_WR,   A_RES,   res_byte, W0);
                default: step = mk(K_END, 3'd0, 8'h00, W0);
            endcase
        end else begin
            unique case (idx)
                5'd0:  step = mk(K_NOP,  3'd0,    8'h00, WS);
                5'd1:  step = mk(K_WR,   A_PWR1,  8'h06, W0);
                5'd2:  step = mk(K_WR,   A_PORT,  8'h08, W0);
                5'd3:  step = mk(K_WR,   A_PWR0,  8'h14, W0);
                5'd4:  step = mk(K_BIAS, 3'd0,    bias_byte, W0);
                5'd5:  step = mk(K_WR,   A_PWR1,  8'h04, W0);
                5'd6:  step = mk(K_WR,   A_PWR0,  8'h04, W0);
                5'd7:  step = mk(K_WR,   A_PORT,  8'h1E, W0);
                5'd8:  step = mk(K_WR,   A_PWR0,  8'h00, W0);
                5'd9:  step = mk(K_WR,   A_PWR1,  8'h00, W0);
                default: step = mk(K_END, 3'd0, 8'h00, W0);
            endcase
        end
    end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
    import lcdseq_pkg::*;
#(
    parameter int CYC_PER_MS = 50000,
    parameter int VDD_MS     = 3,
    parameter int GVSS_MS    = 2,
    parameter int POL_MS     = 1,
    parameter int SETTLE_MS  = 34,
    parameter int DEF_BIAS   = 125,
    parameter int QVGA_PHASE = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_up_req,
    input  logic       suspend_req,
    input  logic       mode_vga,
    input  logic       phase_ok,
    input  logic [7:0] phase_val,
    input  logic       bias_ok,
    input  logic [7:0] bias_stored,
    input  logic       bias_ack,
    output logic       wr_en,
    output logic [2:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       bias_go,
    output logic [7:0] bias_val,
    output logic       busy,
    output logic       done,
    output logic       inited
);
    localparam logic [STEP_W-1:0] PHASE_IDX = STEP_W'(13);
    localparam logic [STEP_W-1:0] RES_IDX   = STEP_W'(15);
    localparam logic [7:0]        BIAS_DEF  = 8'(DEF_BIAS);

    state_t            state;
    logic [STEP_W-1:0] idx, idx_nxt;
    logic              down, skip;
    logic [7:0]        phase_r, res_r, bias_r;
    logic [7:0]        phase_c, res_c;
    step_t             step;
    logic              t_start, t_exp;

    lcdseq_phase_enc #(.QVGA_PHASE(QVGA_PHASE)) u_enc (
        .vga(mode_vga), .ok(phase_ok), .stored(phase_val),
        .phase_byte(phase_c), .res_byte(res_c)
    );

    lcdseq_step_rom #(
        .VDD_MS(VDD_MS), .GVSS_MS(GVSS_MS), .POL_MS(POL_MS), .SETTLE_MS(SETTLE_MS)
    ) u_rom (
        .down(down), .idx(idx), .phase_byte(phase_r), .res_byte(res_r),
        .bias_byte(bias_r), .step(step)
    );

    lcdseq_ms_timer #(.CYC_PER_MS(CYC_PER_MS), .MS_W(WAIT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(t_start), .ms(step.wait_ms), .expired(t_exp)
    );

    assign idx_nxt = (!down && skip && idx == PHASE_IDX) ? RES_IDX : idx + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            idx     <= '0;
            down    <= 1'b0;
            skip    <= 1'b0;
            phase_r <= '0;
            res_r   <= '0;
            bias_r  <= '0;
            inited  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (suspend_req) begin
                        state  <= S_ISSUE;
                        down   <= 1'b1;
                        skip   <= 1'b0;
                        idx    <= '0;
                        bias_r <= 8'h00;
                    end else if (pwr_up_req) begin
                        state   <= S_ISSUE;
                        down    <= 1'b0;
                        skip    <= inited;
                        idx     <= inited ? PHASE_IDX : '0;
                        phase_r <= phase_c;
                        res_r   <= res_c;
                        bias_r  <= bias_ok ? bias_stored : BIAS_DEF;
                    end
                end
                S_ISSUE: begin
                    unique case (step.kind)
                        K_WR, K_NOP: begin
                            if (step.wait_ms != '0) state <= S_HOLD;
                            else idx <= idx_nxt;
                        end
                        K_BIAS: state <= S_BIAS;
                        K_END:  state <= S_FINISH;
                    endcase
                end
                S_HOLD: begin
                    if (t_exp) begin
                        idx   <= idx_nxt;
                        state <= S_ISSUE;
                    end
                end
                S_BIAS: begin
                    if (bias_ack) begin
                        idx   <= idx_nxt;
                        state <= S_ISSUE;
                    end
                end
                S_FINISH: begin
                    inited <= !down;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en    = (state == S_ISSUE) && (step.kind == K_WR);
        wr_addr  = step.addr;
        wr_data  = step.data;
        bias_go  = (state == S_ISSUE) && (step.kind == K_BIAS);
        bias_val = step.data;
        t_start  = (state == S_ISSUE) && (step.kind == K_WR || step.kind == K_NOP)
                   && (step.wait_ms != '0);
        busy     = (state != S_IDLE);
        done     = (state == S_FINISH);
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    inited_moves_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inited != $past(inited)) |-> $past(done));
    // R11
    bias_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bias_go |=> !bias_go && !wr_en);
    // R11
    bias_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BIAS && !bias_ack) |=> !wr_en && !bias_go);
    // R6
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> !wr_en && !bias_go);
    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(pwr_up_req || suspend_req));
    // R2
    addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr != 3'd2 && wr_addr != 3'd5));
endmodule

// File: tb/lcd_pwr_seq_test.sv
module lcd_pwr_seq_test;
    localparam int CLK_NS = 10;
    localparam int CPM    = 4;

    logic clk = 0, rst_n = 0;
    logic pwr_up_req = 0, suspend_req = 0, mode_vga = 0, phase_ok = 0, bias_ok = 0;
    logic [7:0] phase_val = 0, bias_stored = 0;
    logic bias_ack = 0;
    logic wr_en, bias_go, busy, done, inited;
    logic [2:0] wr_addr;
    logic [7:0] wr_data, bias_val;

    int total = 0, bad = 0, cyc = 0;
    logic [11:0] obs [0:63];
    int obs_t [0:63];
    int nobs = 0;
    logic [11:0] ex [0:31];
    int ex_w [0:31];
    int nex = 0;
    int ack_cnt = 0;
    int done_cnt = 0;
    bit model_init = 0;

    lcd_pwr_seq #(.CYC_PER_MS(CPM)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .suspend_req(suspend_req),
        .mode_vga(mode_vga), .phase_ok(phase_ok), .phase_val(phase_val),
        .bias_ok(bias_ok), .bias_stored(bias_stored), .bias_ack(bias_ack),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .bias_go(bias_go),
        .bias_val(bias_val), .busy(busy), .done(done), .inited(inited)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (done) done_cnt = done_cnt + 1;
        if (wr_en && nobs < 64) begin
            obs[nobs] = {1'b0, wr_addr, wr_data}; obs_t[nobs] = cyc; nobs = nobs + 1;
        end
        bias_ack = 1'b0;
        if (ack_cnt > 0) begin
            ack_cnt = ack_cnt - 1;
            if (ack_cnt == 0) bias_ack = 1'b1;
        end
        if (bias_go) begin
            if (nobs < 64) begin
                obs[nobs] = {1'b1, 3'd0, bias_val}; obs_t[nobs] = cyc; nobs = nobs + 1;
            end
            ack_cnt = 1 + int'($urandom % 5);
        end
    end

    initial begin
        #(CLK_NS * 200000);
        bad = bad + 1; total = total + 1;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(bit ok, string what, int act, int expv);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
        end
    endtask

    task automatic add(bit k, logic [2:0] a, logic [7:0] d, int w);
        ex[nex] = {k, a, d}; ex_w[nex] = w; nex = nex + 1;
    endtask

    function automatic logic [7:0] exp_phase(bit vga, bit ok, logic [7:0] v);
        if (!vga) return 8'h13;
        if (!ok) return 8'h01;
        return {3'b0, v[3:0], 1'b1};
    endfunction

    task automatic build_up(bit vga, bit pok, logic [7:0] pv, bit bok, logic [7:0] bv);
        nex = 0;
        if (!model_init) begin
            add(0,6,8'h1F,0); add(0,3,8'h03,0); add(0,4,8'h00,0); add(0,4,8'h04,3);
            add(0,3,8'h07,0); add(0,6,8'h09,0); add(1,0,bok ? bv : 8'd125,0);
            add(0,3,8'h17,0); add(0,4,8'h06,2); add(0,6,8'h01,0); add(0,3,8'h1F,0);
            add(0,4,8'h07,0); add(0,6,8'h00,0);
            add(0,1,exp_phase(vga,pok,pv),0); add(0,7,8'h00,1);
        end else begin
            add(0,1,exp_phase(vga,pok,pv),0);
        end
        add(0,0,vga ? 8'h00 : 8'h01,0);
    endtask

    task automatic build_down();
        nex = 0;
        add(0,4,8'h06,0); add(0,6,8'h08,0); add(0,3,8'h14,0); add(1,0,8'h00,0);
        add(0,4,8'h04,0); add(0,3,8'h04,0); add(0,6,8'h1E,0); add(0,3,8'h00,0);
        add(0,4,8'h00,0);
    endtask

    // kind: 0 power-up, 1 suspend, 2 both at once (suspend wins, R10)
    task automatic run_op(int kind, bit intrude, string tag);
        int t0, wd, d0;
        bit up;
        up = (kind == 0);
        if (up) build_up(mode_vga, phase_ok, phase_val, bias_ok, bias_stored);
        else build_down();
        nobs = 0;
        d0 = done_cnt;
        @(negedge clk);
        pwr_up_req = (kind != 1);
        suspend_req = (kind != 0);
        @(negedge clk);
        pwr_up_req = 0; suspend_req = 0;
        t0 = cyc;
        if (intrude) begin
            repeat (3) @(negedge clk);
            pwr_up_req = 1; suspend_req = 1;
            // R10: change the latched inputs; must not matter mid-run
            mode_vga = ~mode_vga; bias_stored = ~bias_stored;
            @(negedge clk);
            pwr_up_req = 0; suspend_req = 0;
        end
        wd = 0;
        while (busy && wd < 5000) begin @(negedge clk); wd++; end
        @(negedge clk);
        check(nobs == nex, {tag, " event count"}, nobs, nex);
        for (int i = 0; i < nex && i < nobs; i++)
            check(obs[i] == ex[i], $sformatf("%s event %0d (R2 R3 R4 R5 R7 R8 R11)", tag, i),
                  obs[i], ex[i]);
        for (int i = 0; i + 1 < nex && i + 1 < nobs; i++)
            if (ex_w[i] > 0)
                check(obs_t[i+1] - obs_t[i] >= ex_w[i]*CPM && obs_t[i+1] - obs_t[i] <= ex_w[i]*CPM + 4,
                      $sformatf("%s R6 pause after event %0d", tag, i),
                      obs_t[i+1] - obs_t[i], ex_w[i]*CPM);
        if (!up && nobs > 0)
            check(obs_t[0] - t0 >= 34*CPM && obs_t[0] - t0 <= 34*CPM + 6,
                  {tag, " R8 settle wait"}, obs_t[0] - t0, 34*CPM);
        if (up && nobs > 0)
            check(obs[nobs-1][11:8] == 4'h0, {tag, " R5 resolution last"}, obs[nobs-1], 0);
        check(done_cnt - d0 == 1, {tag, " R9 single done pulse"}, done_cnt - d0, 1);
        model_init = up;
        check(inited == model_init, {tag, " R9 R8 inited flag"}, inited, model_init);
        check(!busy, {tag, " idle after sequence"}, busy, 0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(!wr_en && !bias_go && !busy && !done && !inited, "R1 reset state",
              {wr_en, bias_go, busy, done, inited}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(!wr_en && !busy && !inited, "R1 idle after reset", {wr_en, busy, inited}, 0);

        // directed: QVGA, default bias
        mode_vga = 0; phase_ok = 1; phase_val = 8'hA5; bias_ok = 0; bias_stored = 8'h33;
        run_op(0, 0, "up qvga default bias R3 R4");
        // directed: already up, VGA with no valid phase -> short path, 0x01
        mode_vga = 1; phase_ok = 0;
        run_op(0, 0, "up again R7 R4");
        // directed: suspend with a request intruding
        run_op(1, 1, "suspend intruded R10");
        // directed: VGA with stored phase and bias, intruded
        mode_vga = 1; phase_ok = 1; phase_val = 8'h5C; bias_ok = 1; bias_stored = 8'h42;
        run_op(0, 1, "up vga stored R3 R4 R10");
        // directed: both requests together -> suspend
        run_op(2, 0, "both requests R10");
        // random mix
        for (int n = 0; n < 8; n++) begin
            mode_vga = $urandom % 2; phase_ok = $urandom % 2; phase_val = 8'($urandom);
            bias_ok = $urandom % 2; bias_stored = 8'($urandom);
            run_op(($urandom % 3 == 0) ? 1 : 0, $urandom % 2, $sformatf("random %0d", n));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule